// File: doc/BRIEF.md
# Inverter Gate Protection Sequencer

This block sits between a motor-control PWM generator and the six gate drivers of a three-phase inverter bridge. It receives one active-high command per switch (three upper, three lower) together with comparator flags that report lower-supply undervoltage, per-phase upper bias undervoltage and a shared lower-switch overcurrent trip. It passes each command to its gate output only while no protective condition blocks that switch.

A fault on the lower side produces an active-low fault pulse of fixed length, timed in clock cycles by a parameter. Once a switch has been blocked, it stays off until its command shows a new low-to-high edge. Releasing the fault alone, or holding the command high, does not turn it back on. An upper-side bias undervoltage turns off only the upper switch of that phase and produces no fault pulse. All flags and commands are asynchronous to the controller clock and are synchronized inside the block.

Top module: `inv_gate_prot`

## Requirements
- R1: While the synchronized lower-supply undervoltage flag is high, all three lower outputs `drv_lo` are 0 whatever `cmd_lo` holds.
- R2: A low-to-high transition of the synchronized lower-supply undervoltage flag starts a fault pulse. The pulse length is the parameter `PULSE_CYCLES`, whose default of 5000 cycles is about 50 us at a 100 MHz clock.
- R3: While the synchronized short-circuit flag is high, all three lower outputs are 0, including phases whose command is high.
- R4: A low-to-high transition of the synchronized short-circuit flag starts the same fault pulse.
- R5: While the fault pulse is active, every lower output is 0, even when no flag is still set and the command rises.
- R6: Once a blocking condition ends (flag cleared or pulse expired), an output stays 0 until its command goes from 0 to 1 while nothing blocks it.
- R7: Upper bias undervoltage on phase i (bit i of `hsuv_async`, bit 0 = phase U) forces `drv_hi[i]` to 0 only. Other phases, the lower outputs and `flt_n` are unaffected.
- R8: After reset, every supply flag is taken as being in undervoltage, and every output is 0. An output turns on only after its supply flag is clear and its command then rises.
- R9: `flt_n` is 1 in reset and when idle, and it is 0 for exactly `PULSE_CYCLES` consecutive clock cycles per pulse.
- R10: A fault event that arrives while the pulse is active neither restarts nor lengthens the pulse.
- R11: Commands and flags pass through two-flop synchronizers. A command falling edge removes the output after the second rising clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_hi | input | 3 | Upper-switch commands, bit 0 = phase U, active high |
| cmd_lo | input | 3 | Lower-switch commands, bit 0 = phase U, active high |
| lsuv_async | input | 1 | Lower-supply undervoltage flag, asynchronous, high = undervoltage |
| hsuv_async | input | 3 | Per-phase upper bias undervoltage flags, asynchronous |
| sc_async | input | 1 | Shared lower overcurrent trip, asynchronous, high = trip |
| drv_hi | output | 3 | Gated upper-switch drive |
| drv_lo | output | 3 | Gated lower-switch drive |
| flt_n | output | 1 | Fault pulse, active low |

## Verification
The bench holds commands high across the release of undervoltage and overcurrent conditions. A design that re-arms from the command level instead of from an edge would turn a switch back on there. It measures the fault pulse exactly and fires a second fault in the middle of it, which exposes a counter that restarts or has an off-by-one length. It asserts one upper-bias flag at a time to catch a phase mix-up, or a fault pulse wrongly raised for an upper-side event. It also samples one clock edge after a command falls, which would reveal a missing synchronizer stage.

// File: rtl/inv_prot_pkg.sv
// Package: shared constants for the inverter gate protection sequencer.
// Assumes a three-phase bridge with one upper and one lower switch per phase.
package inv_prot_pkg;
    localparam int PHASES    = 3;
    localparam int SYNC_DEPTH = 2;
    localparam int CNT_W     = 16;
endpackage

// File: rtl/prot_sync.sv
// prot_sync: multi-bit two-flop (or deeper) synchronizer for level signals.
// Assumes every bit is an independent level; no bus coherency is implied.
// RESET_VAL sets the value presented while in reset.
module prot_sync #(
    parameter int         WIDTH     = 1,
    parameter int         DEPTH     = 2,
    parameter logic [0:0] RESET_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage [DEPTH];

    // Purpose: shift the asynchronous input through DEPTH flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= {WIDTH{RESET_VAL}};
        end else begin
            stage[0] <= d_async;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q_sync = stage[DEPTH-1];
endmodule

// File: rtl/prot_fault_timer.sv
// prot_fault_timer: one-shot fault pulse generator.
// A trigger while idle starts a pulse of exactly PULSE_CYCLES cycles;
// triggers during an active pulse are ignored (no restart, no extension).
// Assumes PULSE_CYCLES >= 1 and fits in CNT_W bits.
module prot_fault_timer #(
    parameter int CNT_W        = 16,
    parameter int PULSE_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic active
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    logic [CNT_W-1:0] remain;

    // Purpose: load the counter on an idle trigger and count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
        end else if (!active) begin
            if (trigger) begin
                active <= 1'b1;
                remain <= LAST;
            end
        end else if (remain == '0) begin
            active <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/prot_gate_arm.sv
// prot_gate_arm: re-arm gate for one switch.
// The output follows the synchronized command only while armed and unblocked.
// Any blocking condition clears the arm; only a command rising edge seen
// while unblocked sets it again. Assumes cmd_s is already synchronized.
module prot_gate_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    input  logic block,
    output logic drv
);
    logic cmd_q;
    logic armed;
    logic cmd_rise;

    assign cmd_rise = cmd_s & ~cmd_q;

    // Purpose: remember the previous command for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= 1'b0;
        else        cmd_q <= cmd_s;
    end

    // Purpose: clear on any block, set on an unblocked command rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (block)    armed <= 1'b0;
        else if (cmd_rise) armed <= 1'b1;
    end

    assign drv = armed & cmd_s & ~block;
endmodule

// File: rtl/inv_gate_prot.sv
// inv_gate_prot: protection sequencer for a six-switch three-phase bridge.
// Synchronizes commands and flags, blocks lower switches on lower-supply
// undervoltage, overcurrent trip or active fault pulse, blocks each upper
// switch on its own bias undervoltage, and times the active-low fault pulse.
// Assumes flags are high when the condition is present.
module inv_gate_prot
    import inv_prot_pkg::*;
#(
    parameter int PULSE_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] cmd_hi,
    input  logic [PHASES-1:0] cmd_lo,
    input  logic              lsuv_async,
    input  logic [PHASES-1:0] hsuv_async,
    input  logic              sc_async,
    output logic [PHASES-1:0] drv_hi,
    output logic [PHASES-1:0] drv_lo,
    output logic              flt_n
);
    logic [PHASES-1:0] cmd_hi_s, cmd_lo_s, hsuv_s;
    logic              lsuv_s, sc_s, lsuv_q, sc_q;
    logic              fault_evt, pulse_on, lo_block;

    // Commands reset to idle.
    prot_sync #(.WIDTH(2*PHASES), .DEPTH(SYNC_DEPTH), .RESET_VAL(1'b0)) u_cmd_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({cmd_hi, cmd_lo}), .q_sync({cmd_hi_s, cmd_lo_s})
    );
    // Supply flags reset to undervoltage so power-up waits for a good supply.
    prot_sync #(.WIDTH(PHASES+1), .DEPTH(SYNC_DEPTH), .RESET_VAL(1'b1)) u_uv_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({hsuv_async, lsuv_async}), .q_sync({hsuv_s, lsuv_s})
    );
    prot_sync #(.WIDTH(1), .DEPTH(SYNC_DEPTH), .RESET_VAL(1'b0)) u_sc_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async(sc_async), .q_sync(sc_s)
    );

    // Purpose: delay lower-side fault flags for rising-edge event detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsuv_q <= 1'b1;
            sc_q   <= 1'b0;
        end else begin
            lsuv_q <= lsuv_s;
            sc_q   <= sc_s;
        end
    end

    assign fault_evt = (lsuv_s & ~lsuv_q) | (sc_s & ~sc_q);

    prot_fault_timer #(.CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .trigger(fault_evt), .active(pulse_on)
    );

    assign lo_block = lsuv_s | sc_s | pulse_on;
    assign flt_n    = ~pulse_on;

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        prot_gate_arm u_hi (
            .clk(clk), .rst_n(rst_n), .cmd_s(cmd_hi_s[p]),
            .block(hsuv_s[p]), .drv(drv_hi[p])
        );
        prot_gate_arm u_lo (
            .clk(clk), .rst_n(rst_n), .cmd_s(cmd_lo_s[p]),
            .block(lo_block), .drv(drv_lo[p])
        );
    end
endmodule

// File: rtl/inv_gate_prot_chk.sv
// inv_gate_prot_chk: property checker bound to inv_gate_prot.
// Observes the synchronized flags and the block outputs.
module inv_gate_prot_chk #(
    parameter int PHASES       = 3,
    parameter int PULSE_CYCLES = 5000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lsuv_s,
    input logic              sc_s,
    input logic [PHASES-1:0] hsuv_s,
    input logic [PHASES-1:0] drv_hi,
    input logic [PHASES-1:0] drv_lo,
    input logic              flt_n
);
    logic [31:0] low_run;

    // Purpose: count consecutive cycles of flt_n low.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_run <= '0;
        else if (!flt_n) low_run <= low_run + 1;
        else            low_run <= '0;
    end

    a_r1_lsuv_blocks_lo: assert property (@(posedge clk) disable iff (!rst_n)
        lsuv_s |-> (drv_lo == '0));
    a_r3_sc_blocks_lo: assert property (@(posedge clk) disable iff (!rst_n)
        sc_s |-> (drv_lo == '0));
    a_r5_pulse_blocks_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_n |-> (drv_lo == '0));
    a_r7_hsuv_blocks_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (hsuv_s & drv_hi) == '0);
    a_r10_pulse_not_extended: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 32'(PULSE_CYCLES));
    a_r6_lo_on_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_lo[0]) |-> (flt_n && !sc_s && !lsuv_s));
endmodule

bind inv_gate_prot inv_gate_prot_chk #(.PHASES(inv_prot_pkg::PHASES), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .lsuv_s(lsuv_s), .sc_s(sc_s), .hsuv_s(hsuv_s),
    .drv_hi(drv_hi), .drv_lo(drv_lo), .flt_n(flt_n)
);

// File: tb/sim_inv_gate_prot.sv
module sim_inv_gate_prot;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 40;
    localparam int SETTLE     = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_hi = '0, cmd_lo = '0, hsuv_async = 3'b111;
    logic       lsuv_async = 1'b1, sc_async = 1'b0;
    logic [2:0] drv_hi, drv_lo;
    logic       flt_n;
    int         n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inv_gate_prot #(.PULSE_CYCLES(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .lsuv_async(lsuv_async), .hsuv_async(hsuv_async), .sc_async(sc_async),
        .drv_hi(drv_hi), .drv_lo(drv_lo), .flt_n(flt_n)
    );

    // Vector: cmd_hi[16:14] cmd_lo[13:11] lsuv[10] hsuv[9:7] sc[6] exp_hi[5:3] exp_lo[2:0]
    localparam int NV = 17;
    localparam logic [16:0] VEC [NV] = '{
        {3'b000, 3'b000, 1'b1, 3'b111, 1'b0, 3'b000, 3'b000}, // R8 idle in undervoltage
        {3'b111, 3'b111, 1'b1, 3'b111, 1'b0, 3'b000, 3'b000}, // R8 R1 blocked
        {3'b111, 3'b111, 1'b0, 3'b000, 1'b0, 3'b000, 3'b000}, // R8 R6 level is no edge
        {3'b000, 3'b000, 1'b0, 3'b000, 1'b0, 3'b000, 3'b000},
        {3'b101, 3'b010, 1'b0, 3'b000, 1'b0, 3'b101, 3'b010}, // R8 fresh edges
        {3'b101, 3'b010, 1'b0, 3'b001, 1'b0, 3'b100, 3'b010}, // R7 phase U only
        {3'b101, 3'b010, 1'b0, 3'b000, 1'b0, 3'b100, 3'b010}, // R6 R7 no re-arm
        {3'b000, 3'b010, 1'b0, 3'b000, 1'b0, 3'b000, 3'b010},
        {3'b001, 3'b010, 1'b0, 3'b000, 1'b0, 3'b001, 3'b010}, // R6 re-armed
        {3'b001, 3'b010, 1'b0, 3'b000, 1'b1, 3'b001, 3'b000}, // R3 trip held
        {3'b001, 3'b010, 1'b0, 3'b000, 1'b0, 3'b001, 3'b000}, // R6 after trip
        {3'b001, 3'b000, 1'b0, 3'b000, 1'b0, 3'b001, 3'b000},
        {3'b001, 3'b110, 1'b0, 3'b000, 1'b0, 3'b001, 3'b110}, // R6 edge
        {3'b001, 3'b110, 1'b1, 3'b000, 1'b0, 3'b001, 3'b000}, // R1 upper unaffected
        {3'b001, 3'b110, 1'b0, 3'b000, 1'b0, 3'b001, 3'b000}, // R6 after recovery
        {3'b001, 3'b000, 1'b0, 3'b000, 1'b0, 3'b001, 3'b000},
        {3'b001, 3'b011, 1'b0, 3'b000, 1'b0, 3'b001, 3'b011}  // R6 edge
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Returns the length of the next flt_n low run, or -1 if none starts.
    task automatic measure_pulse(output int len);
        int w;
        len = -1;
        w = 0;
        while (flt_n && w < 20) begin @(negedge clk); w++; end
        if (!flt_n) begin
            len = 0;
            while (!flt_n && len < 4*PULSE) begin @(negedge clk); len++; end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        int len;
        cyc(3);
        check("R8 reset drv_hi", drv_hi, 0);
        check("R8 reset drv_lo", drv_lo, 0);
        check("R9 reset flt_n", flt_n, 1);
        rst_n = 1'b1;
        cyc(5);
        check("R8 no pulse from power-up undervoltage", flt_n, 1);

        for (int v = 0; v < NV; v++) begin
            {cmd_hi, cmd_lo, lsuv_async, hsuv_async, sc_async} = VEC[v][16:6];
            cyc(SETTLE);
            check($sformatf("R6 vec %0d drv_hi", v), drv_hi, VEC[v][5:3]);
            check($sformatf("R6 vec %0d drv_lo", v), drv_lo, VEC[v][2:0]);
            check($sformatf("R9 vec %0d flt_n idle", v), flt_n, 1);
        end

        // R7: upper undervoltage raises no fault pulse.
        hsuv_async = 3'b010;
        measure_pulse(len);
        check("R7 no pulse on upper undervoltage", len, -1);
        hsuv_async = 3'b000;
        cyc(5);

        // R4 R9: overcurrent pulse of exact length.
        sc_async = 1'b1;
        measure_pulse(len);
        check("R4 R9 sc pulse length", len, PULSE);
        sc_async = 1'b0;
        cyc(5);

        // R2: lower undervoltage pulse.
        lsuv_async = 1'b1;
        measure_pulse(len);
        check("R2 lsuv pulse length", len, PULSE);
        lsuv_async = 1'b0;
        cyc(5);

        // R10: second event mid-pulse does not extend it.
        sc_async = 1'b1;
        cyc(4);
        sc_async = 1'b0;
        cyc(PULSE/2 - 4);
        lsuv_async = 1'b1;
        cyc(4);
        lsuv_async = 1'b0;
        cyc(PULSE/2 + 4);
        check("R10 pulse over without extension", flt_n, 1);
        cyc(5);

        // R5: short trip, then command rises during the pulse.
        cmd_lo = 3'b000;
        cyc(5);
        sc_async = 1'b1;
        cyc(4);
        sc_async = 1'b0;
        cyc(5);
        check("R5 pulse still active", flt_n, 0);
        cmd_lo = 3'b111;
        cyc(5);
        check("R5 lower off during pulse", drv_lo, 0);
        cyc(PULSE);
        check("R6 lower off after pulse without edge", drv_lo, 0);
        cmd_lo = 3'b000;
        cyc(5);
        cmd_lo = 3'b100;
        cyc(5);
        check("R6 lower on after new edge", drv_lo, 3'b100);

        // R11: two-stage latency on command fall.
        cmd_lo = 3'b000;
        @(posedge clk); #1;
        check("R11 still on after one edge", drv_lo, 3'b100);
        @(posedge clk); #1;
        check("R11 off after second edge", drv_lo, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule